// File: doc/BRIEF.md
# Byte-Lane Scratch Word

This block holds one 32-bit word that a host can read and write through a four-byte I/O window. Each access carries a two-bit byte offset, a size of one to four bytes and, for writes, the write data. The offset picks the first byte lane, and byte lane 0 holds bits 7:0. A write replaces only the addressed lanes and keeps the others. A read returns the addressed lanes shifted down to bit 0, with every higher bit zero.

A select input chooses between two views of the same word. The direct view completes any access in one cycle. The split view runs the access as a series of one-byte operations, one lane per cycle, in ascending lane order. On a read, the split view packs the bytes into the low end of the result.

Accesses that would run past the top lane are clipped to the window. The lanes beyond it are never written, and the read bits that would map to them return zero. The host holds a request with `req_valid` until it sees a one-cycle `req_ready` pulse. The read data is valid in that same cycle.

Top module: `lane_scratch_reg`

## Requirements
- R1: A synchronous active-high reset clears the stored word to zero and holds `req_ready` low.
- R2: `req_size` encodes the byte count minus one (0 means 1 byte, 3 means 4 bytes). The first lane is `req_addr`, the starting bit is `req_addr`×8, and lane 0 holds bits 7:0.
- R3: A direct write replaces exactly the addressed lanes with the low bytes of `req_wdata` in order. Other lanes and write-data bits above the access size have no effect.
- R4: A direct read returns the addressed lanes right-justified in `rsp_rdata`, with all bits above the access size equal to zero.
- R5: When offset plus size exceeds 4, only lanes up to lane 3 are written or read, and read bits for lanes outside the window are zero.
- R6: A direct access raises `req_ready` on the clock edge after it is first seen, so it completes in one cycle.
- R7: `req_ready` is a one-cycle pulse. The request is taken again only after `req_ready` has fallen.
- R8: A split access takes one cycle per lane actually touched, which is min(size, 4 − offset) cycles, and raises `req_ready` only after the last lane.
- R9: A split write leaves the stored word exactly as a direct write with the same offset, size and data would.
- R10: A split read returns the touched lanes packed in lane order into the low bytes of `rsp_rdata`, with the remaining bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_alias | input | 1 | 1 selects the split one-byte-per-cycle view |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 2 | Starting byte lane |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid while `req_ready` is high |

## Verification
The bench uses the default 32-bit word with 8-bit lanes, which gives four lanes and a two-bit offset. At this size every offset, every size and every clipped overhang can be reached with a few vectors. The split sequencer is driven at all four of its lengths (1 to 4 cycles), so each latency and each clip point is measured at the ports. Read-backs through the direct view confirm that split writes leave the same word a direct write would.

// File: rtl/lane_scratch_pkg.sv
package lane_scratch_pkg;
  localparam int SCR_DATA_W = 32;
  localparam int SCR_LANE_W = 8;

  // number of lanes an access really touches once clipped to the window
  function automatic int clip_lanes(input int off, input int szm1, input int lanes);
    int want;
    int room;
    want = szm1 + 1;
    room = lanes - off;
    return (want < room) ? want : room;
  endfunction
endpackage

// File: rtl/lane_mask_unit.sv
module lane_mask_unit #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W-1:0]  szm1,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd
);
  logic [OFF_W:0] first_l;
  logic [OFF_W:0] last_l;

  assign first_l = {1'b0, off};
  assign last_l  = {1'b0, off} + {1'b0, szm1};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W:0] IDX = i;
    assign mask[i*LANE_W +: LANE_W] =
      ((IDX >= first_l) && (IDX <= last_l)) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
  end

  // shifting by the lane offset drops bits past the top lane (clipping)
  assign merged = (cur & ~mask) | ((wdata << (off * LANE_W)) & mask);
  assign rd     = (cur & mask) >> (off * LANE_W);
endmodule

// File: rtl/alias_byte_seq.sv
module alias_byte_seq #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [OFF_W:0]   cnt,
  output logic [OFF_W-1:0] idx,
  output logic             last
);
  localparam logic [OFF_W:0]   ONE_W = 1;
  localparam logic [OFF_W-1:0] ONE_N = 1;

  logic [OFF_W-1:0] idx_q;

  assign idx  = idx_q;
  assign last = (({1'b0, idx_q} + ONE_W) == cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (step) begin
      idx_q <= last ? '0 : idx_q + ONE_N;
    end
  end

  // R8
  seq_idx_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> ({1'b0, idx_q} < cnt));
endmodule

// File: rtl/lane_scratch_reg.sv
module lane_scratch_reg
  import lane_scratch_pkg::*;
#(
  parameter int DATA_W = SCR_DATA_W,
  parameter int LANE_W = SCR_LANE_W,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_alias,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_addr,
  input  logic [OFF_W-1:0]  req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] store_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  logic              active;
  logic [OFF_W:0]    cnt;
  logic [OFF_W-1:0]  idx;
  logic              seq_last;
  logic [OFF_W-1:0]  op_off;
  logic [OFF_W-1:0]  op_szm1;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] op_mask;
  logic [DATA_W-1:0] op_merged;
  logic [DATA_W-1:0] op_rd;

  assign active = req_valid && !ready_q;
  assign cnt    = (OFF_W+1)'(clip_lanes(int'(req_addr), int'(req_size), LANES));

  alias_byte_seq #(.LANES(LANES)) seq_i (
    .clk  (clk),
    .rst  (rst),
    .step (active && req_alias),
    .cnt  (cnt),
    .idx  (idx),
    .last (seq_last)
  );

  // split view: one lane per cycle, direct view: whole access at once
  assign op_off   = req_alias ? (req_addr + idx) : req_addr;
  assign op_szm1  = req_alias ? '0 : req_size;
  assign op_wdata = req_alias ? (req_wdata >> (idx * LANE_W)) : req_wdata;

  lane_mask_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) lane_i (
    .off    (op_off),
    .szm1   (op_szm1),
    .cur    (store_q),
    .wdata  (op_wdata),
    .mask   (op_mask),
    .merged (op_merged),
    .rd     (op_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (active) begin
        if (req_write) begin
          store_q <= op_merged;
        end
        if (req_alias) begin
          rdata_q <= ((idx == '0) ? '0 : rdata_q) | (op_rd << (idx * LANE_W));
          if (seq_last) begin
            ready_q <= 1'b1;
          end
        end else begin
          rdata_q <= op_rd;
          ready_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready = ready_q;
  assign rsp_rdata = rdata_q;

  // R7
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> !ready_q);

  // R6
  direct_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_alias && !ready_q) |=> ready_q);

  // R3
  keep_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (active && req_write) |=> (((store_q ^ $past(store_q)) & ~$past(op_mask)) == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(active && req_write) |=> $stable(store_q));
endmodule

// File: tb/lane_scratch_reg_tb_top.sv
module lane_scratch_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_alias = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_scratch_reg dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_alias(req_alias),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata)
  );

  // {alias, write, addr, size-1, wdata, expected read, expected cycles}
  localparam int NV = 19;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 2'd3, 32'h44332211, 32'h0,        3'd1},
    {1'b0, 1'b0, 2'd0, 2'd3, 32'h0,        32'h44332211, 3'd1},
    {1'b0, 1'b1, 2'd1, 2'd0, 32'h000000AA, 32'h0,        3'd1}, // R2 lane 1
    {1'b0, 1'b0, 2'd0, 2'd3, 32'h0,        32'h4433AA11, 3'd1},
    {1'b0, 1'b0, 2'd2, 2'd1, 32'h0,        32'h00004433, 3'd1},
    {1'b0, 1'b1, 2'd2, 2'd1, 32'h0000BEEF, 32'h0,        3'd1},
    {1'b0, 1'b0, 2'd1, 2'd1, 32'h0,        32'h0000EFAA, 3'd1},
    {1'b0, 1'b1, 2'd3, 2'd1, 32'h00005566, 32'h0,        3'd1}, // R5 clipped write
    {1'b0, 1'b0, 2'd3, 2'd3, 32'h0,        32'h00000066, 3'd1}, // R5 clipped read
    {1'b1, 1'b1, 2'd0, 2'd3, 32'hDDCCBBAA, 32'h0,        3'd4},
    {1'b0, 1'b0, 2'd0, 2'd3, 32'h0,        32'hDDCCBBAA, 3'd1},
    {1'b1, 1'b0, 2'd1, 2'd1, 32'h0,        32'h0000CCBB, 3'd2},
    {1'b1, 1'b1, 2'd2, 2'd3, 32'h12345678, 32'h0,        3'd2}, // R5 split clip
    {1'b1, 1'b0, 2'd0, 2'd3, 32'h0,        32'h5678BBAA, 3'd4},
    {1'b1, 1'b0, 2'd3, 2'd2, 32'h0,        32'h00000056, 3'd1}, // R5
    {1'b1, 1'b1, 2'd1, 2'd2, 32'h0000FF00, 32'h0,        3'd3},
    {1'b0, 1'b0, 2'd0, 2'd3, 32'h0,        32'h00FF00AA, 3'd1},
    {1'b0, 1'b1, 2'd0, 2'd0, 32'hFFFFFF5A, 32'h0,        3'd1}, // R3 upper data ignored
    {1'b0, 1'b0, 2'd0, 2'd3, 32'h0,        32'h00FF005A, 3'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic al, input logic wr, input logic [1:0] ad,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_alias = al; req_write = wr;
    req_addr = ad; req_size = sz; req_wdata = wd;
    lat = 0;
    rd = '0;
    while (lat < 8) begin
      @(posedge clk); #1;
      lat++;
      if (req_ready) break;
    end
    rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    // R7 pulse lasts one cycle
    check("R7", {31'b0, req_ready}, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    repeat (3) @(posedge clk);
    #1;
    // R1 ready low in reset
    check("R1", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    // R1 word reads zero after reset
    access(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, rd, lat);
    check("R1", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      access(v[72], v[71], v[70:69], v[68:67], v[66:35], rd, lat);
      if (!v[71]) check(v[72] ? "R10" : "R4", rd, v[34:3]);
      check(v[72] ? "R8" : "R6", 32'(lat), 32'(v[2:0]));
    end

    // R9 split write of a full word equals direct write result
    access(1'b1, 1'b1, 2'd0, 2'd3, 32'hCAFEF00D, rd, lat);
    access(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, rd, lat);
    check("R9", rd, 32'hCAFEF00D);

    // R2 single byte at lane 3 lands in bits 31:24
    access(1'b0, 1'b1, 2'd3, 2'd0, 32'h00000011, rd, lat);
    access(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, rd, lat);
    check("R2", rd, 32'h11FEF00D);

    // R1 reset mid-run clears the word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, 1'b0, 2'd0, 2'd3, 32'h0, rd, lat);
    check("R1", rd, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule